// File: doc/BRIEF.md
# Frequency Display Blanking Controller

This block decides which digits of a multi-digit seven-segment frequency readout are lit. It holds the reading on display, and a new reading arrives as a whole word of BCD digits over a valid/ready port. A reading that has been accepted waits in a one-slot holding register. It reaches the display only when the main gate waveform has its next falling edge, so the readout never changes partway through a measurement. The block drives a per-digit blank mask and a global display enable for the segment decoder and the anode drivers. Neither of those is part of this block.

Per-digit blanking comes from two sources. The first is leading-zero suppression, which runs as a ripple chain from the most significant digit downward. The range-select input can also force the top digit off. The second source is a pair of tune-mode inputs, each of which blanks one of the two lowest digits.

Global blanking overrides every per-digit rule. It occurs in two cases. The first is loss of lock in the synthesizer loop: the lock input is synchronised first, and the display stays dark for as long as lock is lost. The second is a short timed blank after each gate falling edge, which lets the display multiplex resynchronise.

Back-pressure: `in_ready` is high only while the holding slot is empty. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. After that, `in_ready` stays low until the next gate falling edge moves the word to the display. The source must hold `in_digits` stable while `in_valid` is high and `in_ready` is low.

Top module: `freq_blank_ctrl`

## Requirements
- R1: While reset is held and after it is released, `blank_mask` is all ones, `disp_en` is 0, `disp_digits` is 0 and `in_ready` is 1. The lock synchroniser resets to "unlocked", so the display stays dark until lock has been seen on two clock edges.
- R2: With `lz_en`=1, digit i (digit 0 is least significant; digit i sits in `in_digits[4i+3:4i]`) is blanked when it holds 0 and every more significant digit is also blanked. A zero that lies below a nonzero digit stays lit.
- R3: Leading-zero suppression never blanks digit 0. An all-zero reading with `lz_en`=1 shows only digit 0.
- R4: With `lz_en`=0 and `range_low`=0, no digit is blanked by zero suppression.
- R5: With `range_low`=1, the top digit is blanked whatever its value. The ripple chain then runs from it downward as if `lz_en` were 1, so the next digit is blanked whenever it is zero.
- R6: `tune_a`=1 blanks digit 0 and `tune_b`=1 blanks digit 1. Each acts independently of the other and of the value shown.
- R7: When `lock_ok` goes low, `disp_en` is low and `blank_mask` is all ones from the second rising edge on. When `lock_ok` returns high, the display returns on the second rising edge, unless a gate blank is still active.
- R8: A falling edge of `gate_in` (high sampled on one edge, low on the next) starts a global blank. The blank lasts exactly `PULSE_CYCLES` clock cycles and begins on that same edge. A rising edge of `gate_in` starts nothing.
- R9: `in_ready` is 1 only while the holding slot is empty. A word is taken on an edge with `in_valid` and `in_ready` both high. While the slot is full, `in_valid` has no effect.
- R10: `disp_digits` changes only on the edge that detects a gate falling edge, and only if the holding slot is full. On that edge it takes the held word and the slot empties.
- R11: Global blanking overrides the per-digit rules: while it is active, every mask bit is 1 and `disp_en` is 0, whatever the digits, `lz_en`, `range_low` and the tune inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new reading is offered |
| in_ready | output | 1 | Holding slot is empty |
| in_digits | input | NUM_DIGITS*4 | BCD reading, digit 0 in the low nibble |
| gate_in | input | 1 | Main gate waveform, synchronous to clk |
| lock_ok | input | 1 | Loop lock status, asynchronous, high = locked |
| lz_en | input | 1 | Enables leading-zero suppression |
| range_low | input | 1 | Lowest frequency range selected |
| tune_a | input | 1 | Blanks digit 0 |
| tune_b | input | 1 | Blanks digit 1 |
| disp_digits | output | NUM_DIGITS*4 | Reading currently on display |
| blank_mask | output | NUM_DIGITS | 1 = digit dark |
| disp_en | output | 1 | 0 = whole display dark |

## Verification
The bench covers the following corner cases, and for each one names the symptom of a wrong design.
- All-zero readings with suppression on. A chain that includes digit 0 would show an empty display.
- Zeros trapped below a nonzero digit. Per-digit zero blanking without the ripple would dark them.
- The low-range case where the forced top digit has to keep the chain going. Without this, the zero in the next digit would stay lit.
- Both tune inputs together, applied to an all-zero reading.
- The exact length of the gate blank. A counter that is off by one stretches or clips it by a cycle.
- A word offered while the slot is full. A design without back-pressure would overwrite the held reading or show it before the gate falls.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;

  function automatic logic bcd_is_zero(input bcd_t d);
    return (d == '0);
  endfunction
endpackage

// File: rtl/fbc_lock_sync.sv
module fbc_lock_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  output logic lock_s
);
  logic lock_meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_meta <= 1'b0;
      lock_s    <= 1'b0;
    end else begin
      lock_meta <= lock_raw;
      lock_s    <= lock_meta;
    end
  end

  // a drop in lock must have passed through the first stage
  assert_lock_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_s) |-> !$past(lock_meta));
  assert_lock_rise_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_s) |-> $past(lock_meta));
endmodule

// File: rtl/fbc_gate_timer.sv
module fbc_gate_timer #(
  parameter int unsigned PULSE_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_fall,
  output logic pulse_active
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic             gate_q;
  logic [CNT_W-1:0] cnt;

  assign gate_fall    = gate_q & ~gate_in;
  assign pulse_active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt    <= '0;
    end else begin
      gate_q <= gate_in;
      if (gate_fall)         cnt <= CNT_LOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assert_pulse_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fall |=> (cnt == CNT_LOAD));
  assert_pulse_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active && !gate_fall) |=> (cnt == $past(cnt) - 1'b1));
  assert_pulse_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LOAD);
  assert_no_start_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_active && !gate_fall) |=> (cnt == '0));
endmodule

// File: rtl/fbc_update_hold.sv
module fbc_update_hold #(
  parameter int unsigned NUM_DIGITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_DIGITS*4-1:0] in_digits,
  input  logic                    gate_fall,
  output logic [NUM_DIGITS*4-1:0] disp_digits
);
  localparam int unsigned WORD_W = NUM_DIGITS * 4;

  logic [WORD_W-1:0] pend_q;
  logic              pend_full;
  logic              take;

  assign in_ready = ~pend_full;
  assign take     = in_valid & ~pend_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      pend_full   <= 1'b0;
      disp_digits <= '0;
    end else begin
      if (take) begin
        pend_q    <= in_digits;
        pend_full <= 1'b1;
      end else if (gate_fall && pend_full) begin
        disp_digits <= pend_q;
        pend_full   <= 1'b0;
      end
    end
  end

  assert_display_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_fall |=> $stable(disp_digits));
  assert_ready_drops_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_held_word_shown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_fall && !in_ready) |=> (in_ready && disp_digits == $past(pend_q)));
endmodule

// File: rtl/fbc_digit_blank.sv
module fbc_digit_blank
  import fbc_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 6
) (
  input  logic [NUM_DIGITS*4-1:0] digits,
  input  logic                    lz_en,
  input  logic                    range_low,
  input  logic                    tune_a,
  input  logic                    tune_b,
  output logic [NUM_DIGITS-1:0]   digit_mask
);
  localparam int unsigned TOP = NUM_DIGITS - 1;

  logic [NUM_DIGITS-1:0] zero;
  logic [NUM_DIGITS-1:0] lz_blank;
  logic [NUM_DIGITS-1:0] trail_blank;
  logic                  chain_on;

  assign chain_on = lz_en | range_low;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    assign zero[g] = bcd_is_zero(digits[g*BCD_W +: BCD_W]);

    if (g == TOP) begin : g_top
      assign lz_blank[g] = range_low | (lz_en & zero[g]);
    end else if (g == 0) begin : g_lsd
      assign lz_blank[g] = 1'b0;
    end else begin : g_mid
      assign lz_blank[g] = lz_blank[g+1] & zero[g] & chain_on;
    end

    if (g == 0) begin : g_ta
      assign trail_blank[g] = tune_a;
    end else if (g == 1) begin : g_tb
      assign trail_blank[g] = tune_b;
    end else begin : g_tn
      assign trail_blank[g] = 1'b0;
    end
  end

  assign digit_mask = lz_blank | trail_blank;

  // suppression below the top digit only ever removes zeros
  for (genvar g = 1; g < TOP; g++) begin : g_chk
    always_comb begin
      assert_lz_only_zero_R2: assert (!lz_blank[g] || zero[g]);
    end
  end
endmodule

// File: rtl/freq_blank_ctrl.sv
module freq_blank_ctrl #(
  parameter int unsigned NUM_DIGITS   = 6,
  parameter int unsigned PULSE_CYCLES = 125000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_DIGITS*4-1:0] in_digits,
  input  logic                    gate_in,
  input  logic                    lock_ok,
  input  logic                    lz_en,
  input  logic                    range_low,
  input  logic                    tune_a,
  input  logic                    tune_b,
  output logic [NUM_DIGITS*4-1:0] disp_digits,
  output logic [NUM_DIGITS-1:0]   blank_mask,
  output logic                    disp_en
);
  logic                  lock_s;
  logic                  gate_fall;
  logic                  pulse_active;
  logic                  global_blank;
  logic [NUM_DIGITS-1:0] digit_mask;

  fbc_lock_sync u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_raw (lock_ok),
    .lock_s   (lock_s)
  );

  fbc_gate_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_in      (gate_in),
    .gate_fall    (gate_fall),
    .pulse_active (pulse_active)
  );

  fbc_update_hold #(.NUM_DIGITS(NUM_DIGITS)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_digits   (in_digits),
    .gate_fall   (gate_fall),
    .disp_digits (disp_digits)
  );

  fbc_digit_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
    .digits     (disp_digits),
    .lz_en      (lz_en),
    .range_low  (range_low),
    .tune_a     (tune_a),
    .tune_b     (tune_b),
    .digit_mask (digit_mask)
  );

  assign global_blank = ~lock_s | pulse_active;
  assign disp_en      = ~global_blank;
  assign blank_mask   = global_blank ? '1 : digit_mask;

  assert_unlock_darkens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_s |-> (!disp_en && (&blank_mask)));
  assert_lsd_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !tune_a) |-> !blank_mask[0]);
  assert_gate_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fall |=> !disp_en);
endmodule

// File: tb/freq_blank_ctrl_test.sv
module freq_blank_ctrl_test;
  localparam int unsigned ND  = 6;
  localparam int unsigned PC  = 8;
  localparam int unsigned NV  = 10;
  // {digits[23:0], lz_en, range_low, tune_a, tune_b, expected mask[5:0]}
  localparam logic [33:0] VEC [NV] = '{
    {24'h012345, 4'b1000, 6'b100000},  // R2 single leading zero
    {24'h000000, 4'b1000, 6'b111110},  // R3 all zero keeps digit 0
    {24'h000000, 4'b0000, 6'b000000},  // R4 suppression off
    {24'h102030, 4'b1000, 6'b000000},  // R2 inner zeros stay lit
    {24'h001234, 4'b0100, 6'b110000},  // R5 forced top, zero below
    {24'h090000, 4'b0100, 6'b100000},  // R5 forced top, nonzero below
    {24'h123456, 4'b1010, 6'b000001},  // R6 tune_a
    {24'h123456, 4'b1001, 6'b000010},  // R6 tune_b
    {24'h000000, 4'b1011, 6'b111111},  // R6 both tunes on zero reading
    {24'h000700, 4'b1000, 6'b111000}   // R2 ripple stops at nonzero
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ND*4-1:0] in_digits = '0;
  logic gate_in = 1'b0;
  logic lock_ok = 1'b0;
  logic lz_en = 1'b0, range_low = 1'b0, tune_a = 1'b0, tune_b = 1'b0;
  logic [ND*4-1:0] disp_digits;
  logic [ND-1:0] blank_mask;
  logic disp_en;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  freq_blank_ctrl #(.NUM_DIGITS(ND), .PULSE_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_digits(in_digits), .gate_in(gate_in), .lock_ok(lock_ok),
    .lz_en(lz_en), .range_low(range_low), .tune_a(tune_a), .tune_b(tune_b),
    .disp_digits(disp_digits), .blank_mask(blank_mask), .disp_en(disp_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [ND*4-1:0] d);
    in_digits = d;
    in_valid  = 1'b1;
    cyc(1);
    in_valid  = 1'b0;
  endtask

  // gate high for one edge, then low: falling edge seen on the following edge
  task automatic gate_pulse();
    gate_in = 1'b1;
    cyc(1);
    gate_in = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 mask", 32'(blank_mask), 32'h3f);
    check("R1 en", 32'(disp_en), 0);
    check("R1 ready", 32'(in_ready), 1);
    check("R1 digits", 32'(disp_digits), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 dark until lock", 32'(disp_en), 0);
    lock_ok = 1'b1;
    cyc(1);
    check("R7 one edge not enough", 32'(disp_en), 0);
    cyc(1);
    check("R7 lock seen", 32'(disp_en), 1);

    for (int v = 0; v < NV; v++) begin
      {lz_en, range_low, tune_a, tune_b} = VEC[v][9:6];
      push(VEC[v][33:10]);
      gate_pulse();
      check("R8 blank starts", 32'(disp_en), 0);
      check("R11 all dark in pulse", 32'(blank_mask), 32'h3f);
      cyc(PC - 1);
      check("R8 blank still on", 32'(disp_en), 0);
      cyc(1);
      check("R8 blank ends", 32'(disp_en), 1);
      check("R10 word shown", 32'(disp_digits), 32'(VEC[v][33:10]));
      check("R2 R3 R4 R5 R6 mask", 32'(blank_mask), 32'(VEC[v][5:0]));
    end

    // R9 back-pressure, R10 hold until gate falls
    lz_en = 1'b0; range_low = 1'b0; tune_a = 1'b0; tune_b = 1'b0;
    push(24'h111111);
    check("R9 ready low when full", 32'(in_ready), 0);
    push(24'h222222);
    cyc(3);
    check("R10 display unchanged before gate", 32'(disp_digits), 32'h000700);
    gate_in = 1'b1;
    cyc(2);
    check("R8 rise starts no blank", 32'(disp_en), 1);
    gate_in = 1'b0;
    cyc(1);
    check("R9 second word ignored", 32'(disp_digits), 32'h111111);
    check("R9 ready after transfer", 32'(in_ready), 1);
    cyc(PC);
    check("R8 pulse done", 32'(disp_en), 1);

    // R7 and R11 loss of lock
    lz_en = 1'b1; tune_a = 1'b0;
    cyc(1);
    lock_ok = 1'b0;
    cyc(1);
    check("R7 one edge after drop", 32'(disp_en), 1);
    cyc(1);
    check("R7 dark after two edges", 32'(disp_en), 0);
    check("R11 mask overrides", 32'(blank_mask), 32'h3f);
    lock_ok = 1'b1;
    cyc(2);
    check("R7 display back", 32'(disp_en), 1);
    check("R2 mask after recovery", 32'(blank_mask), 32'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule